// File: doc/BRIEF.md
# Multi-Branch Fetch Address Cache

This block is a tagged, direct-mapped table that a fetch unit consults with a single fetch address. Each entry describes a small binary tree of basic-block successors. The root is the primary branch. Each level below it holds the taken and the fall-through start address of every branch that can be reached at that level. A lookup walks the tree with a vector of predicted directions, one bit per level, supplied by an external global-history direction predictor. The result is a chain of block start addresses, one per level, that the fetch unit can issue in the same cycle.

Lookups are combinational from the fetch address and the prediction bits. On a tag miss the fetch unit falls back to the next sequential fetch block, and the block computes that address for it. After a branch resolves, a write port installs or replaces a whole entry. The write takes effect at the next clock edge. With the default of two levels an entry stores three branch descriptors and six addresses. With three levels it would store seven descriptors and fourteen addresses.

Top module: `btc_top`

## Requirements
- R1: The fetch address is split as {tag, index, offset}. The offset is the low log2(FETCH_BYTES) bits and the index is the next IDX_W bits. `hit` is 1 only when the indexed entry has been installed and its stored tag equals the tag bits. `miss` is always the inverse of `hit`.
- R2: After reset, asynchronous and active low, every index misses until a write installs it.
- R3: `seq_addr` always equals `fetch_addr + FETCH_BYTES`. On a miss, every bit of `lvl_vld` and `lvl_addr` is 0.
- R4: Level 0 is steered by `pred_dir[0]` through branch node 0. Direction 1 (taken) selects address slot 1 and direction 0 selects slot 0. The result appears at `lvl_addr[ADDR_W-1:0]`.
- R5: Level 1 is steered by `pred_dir[1]` through the branch node reached at level 0. Node 2 is reached on the taken side and node 1 on the fall-through side. The level-1 address comes from slot 2*node+direction, so slot 2 = fall-through/fall-through, 3 = fall-through/taken, 4 = taken/fall-through and 5 = taken/taken.
- R6: Level k is valid only when there is a hit and the valid bit of every branch node on the walked path up to and including level k is set. A level that is not valid outputs an all-zero address.
- R7: The 2-bit branch kind is encoded as conditional = 00, unconditional = 01, return = 10, none = 11. Conditional and return follow the prediction bit. Unconditional forces taken. None forces fall-through.
- R8: A write updates its entry at the next rising clock edge and replaces the tag as well. A lookup of the same index in the write cycle returns the old contents. After a replacement, the previous tag misses.
- R9: Write-port layout: branch node n has its valid bit at `wr_br_vld[n]` and its kind at `wr_br_kind[2n+1:2n]`. Address slot s is at `wr_tgt[ADDR_W*s +: ADDR_W]`.
- R10: The offset bits of the fetch address have no effect on `hit` or on the level outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Current fetch address for lookup |
| pred_dir | input | LEVELS | Predicted directions, bit k for level k (1 = taken) |
| hit | output | 1 | Lookup found a matching entry |
| miss | output | 1 | Lookup found no matching entry |
| lvl_vld | output | LEVELS | Per-level validity of the returned block addresses |
| lvl_addr | output | ADDR_W*LEVELS | Block start address for level k at bits [ADDR_W*k +: ADDR_W] |
| seq_addr | output | ADDR_W | Sequential fallback address |
| wr_en | input | 1 | Install or replace an entry |
| wr_addr | input | ADDR_W | Fetch address that identifies the entry to write |
| wr_br_vld | input | 2^LEVELS-1 | Valid bit per branch node |
| wr_br_kind | input | 2*(2^LEVELS-1) | Branch kind per node |
| wr_tgt | input | ADDR_W*(2^(LEVELS+1)-2) | Address slots of the tree |

## Verification
The bench sweeps every index, every prediction pair and several offsets. It checks the tree walk against the slot numbering, so a design that swaps the taken and fall-through halves, or that indexes level 1 with the wrong prediction bit, returns a wrong address on some combination. It installs every pairing of primary and secondary branch kinds, which exposes an unconditional branch that fails to force taken or a "none" kind treated as conditional. It also installs every valid-bit pattern: a design that checks only the leaf's valid bit, and not the whole path, would report level 1 valid behind an invalid primary. A lookup in the same cycle as a write to that entry must still see the old entry, which catches write forwarding. A replaced tag must then miss, which catches a write that leaves the old tag behind.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    BR_COND   = 2'b00,
    BR_UNCOND = 2'b01,
    BR_RET    = 2'b10,
    BR_NONE   = 2'b11
  } br_kind_e;

  // Resolve the direction taken at one tree node: 1 = taken side.
  function automatic logic pick_dir(input logic [1:0] kind, input logic pred);
    logic d;
    case (kind)
      BR_UNCOND: d = 1'b1;
      BR_NONE:   d = 1'b0;
      default:   d = pred;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/btc_addr_split.sv
module btc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  logic unused_offset;

  assign idx           = addr[OFF_W +: IDX_W];
  assign tag           = addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^addr[OFF_W-1:0];

endmodule

// File: rtl/btc_table.sv
module btc_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 24,
  parameter int NODES  = 3,
  parameter int SLOTS  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [NODES-1:0]        wr_br_vld,
  input  logic [2*NODES-1:0]      wr_br_kind,
  input  logic [ADDR_W*SLOTS-1:0] wr_tgt,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [TAG_W-1:0]        rd_tag,
  output logic                    rd_hit,
  output logic [NODES-1:0]        rd_br_vld,
  output logic [2*NODES-1:0]      rd_br_kind,
  output logic [ADDR_W*SLOTS-1:0] rd_tgt
);

  logic [DEPTH-1:0]        present_q;
  logic [DEPTH-1:0]        present_d;
  logic [TAG_W-1:0]        tag_q  [DEPTH];
  logic [NODES-1:0]        bvld_q [DEPTH];
  logic [2*NODES-1:0]      kind_q [DEPTH];
  logic [ADDR_W*SLOTS-1:0] tgt_q  [DEPTH];

  // Next-state for the installed flags.
  always_comb begin
    present_d = present_q;
    if (wr_en) begin
      present_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
    end else begin
      present_q <= present_d;
    end
  end

  // Payload storage: no reset, qualified by the installed flag.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      bvld_q[wr_idx] <= wr_br_vld;
      kind_q[wr_idx] <= wr_br_kind;
      tgt_q[wr_idx]  <= wr_tgt;
    end
  end

  // Read side sees register contents only, so a same-cycle write is not visible.
  assign rd_hit     = present_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_br_vld  = bvld_q[rd_idx];
  assign rd_br_kind = kind_q[rd_idx];
  assign rd_tgt     = tgt_q[rd_idx];

  // R8: an entry written at one edge is installed after it.
  assert_install_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> present_q[$past(wr_idx)]);

  // R8: without a write the installed set does not change.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(present_q));

endmodule

// File: rtl/btc_walk.sv
module btc_walk #(
  parameter int ADDR_W = 32,
  parameter int LEVELS = 2,
  localparam int NODES  = (1 << LEVELS) - 1,
  localparam int SLOTS  = (1 << (LEVELS + 1)) - 2,
  localparam int SLOT_W = LEVELS + 1,
  localparam int PADN   = 1 << SLOT_W
) (
  input  logic                     hit,
  input  logic [LEVELS-1:0]        pred,
  input  logic [NODES-1:0]         br_vld,
  input  logic [2*NODES-1:0]       br_kind,
  input  logic [ADDR_W*SLOTS-1:0]  tgt,
  output logic [LEVELS-1:0]        lvl_vld,
  output logic [ADDR_W*LEVELS-1:0] lvl_addr
);

  logic              vld_a  [PADN];
  logic [1:0]        kind_a [PADN];
  logic [ADDR_W-1:0] tgt_a  [PADN];

  // Unpack to power-of-two arrays so node and slot indices line up exactly.
  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      vld_a[n]  = br_vld[n];
      kind_a[n] = br_kind[2*n +: 2];
    end
    for (int n = NODES; n < PADN; n++) begin
      vld_a[n]  = 1'b0;
      kind_a[n] = 2'b00;
    end
    for (int s = 0; s < SLOTS; s++) begin
      tgt_a[s] = tgt[ADDR_W*s +: ADDR_W];
    end
    for (int s = SLOTS; s < PADN; s++) begin
      tgt_a[s] = '0;
    end
  end

  logic [SLOT_W-1:0] node;
  logic [SLOT_W-1:0] slot;
  logic              chain;
  logic              dir;

  // Walk the tree: node n has fall-through slot 2n and taken slot 2n+1;
  // the next node is that slot number plus one.
  always_comb begin
    lvl_vld  = '0;
    lvl_addr = '0;
    node     = '0;
    slot     = '0;
    dir      = 1'b0;
    chain    = hit;
    for (int k = 0; k < LEVELS; k++) begin
      chain = chain & vld_a[node];
      dir   = btc_pkg::pick_dir(kind_a[node], pred[k]);
      slot  = {node[SLOT_W-2:0], dir};
      lvl_vld[k] = chain;
      if (chain) begin
        lvl_addr[ADDR_W*k +: ADDR_W] = tgt_a[slot];
      end
      node = slot + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/btc_top.sv
module btc_top #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int FETCH_BYTES = 16,
  parameter int LEVELS      = 2,
  localparam int NODES = (1 << LEVELS) - 1,
  localparam int SLOTS = (1 << (LEVELS + 1)) - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic [LEVELS-1:0]        pred_dir,
  output logic                     hit,
  output logic                     miss,
  output logic [LEVELS-1:0]        lvl_vld,
  output logic [ADDR_W*LEVELS-1:0] lvl_addr,
  output logic [ADDR_W-1:0]        seq_addr,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NODES-1:0]         wr_br_vld,
  input  logic [2*NODES-1:0]       wr_br_kind,
  input  logic [ADDR_W*SLOTS-1:0]  wr_tgt
);

  localparam int OFF_W = $clog2(FETCH_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]        rd_idx;
  logic [TAG_W-1:0]        rd_tag;
  logic [IDX_W-1:0]        wr_idx;
  logic [TAG_W-1:0]        wr_tag;
  logic [NODES-1:0]        rd_br_vld;
  logic [2*NODES-1:0]      rd_br_kind;
  logic [ADDR_W*SLOTS-1:0] rd_tgt;

  btc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) rd_split_i (
    .addr (fetch_addr),
    .idx  (rd_idx),
    .tag  (rd_tag)
  );

  btc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) wr_split_i (
    .addr (wr_addr),
    .idx  (wr_idx),
    .tag  (wr_tag)
  );

  btc_table #(
    .ADDR_W (ADDR_W), .IDX_W (IDX_W), .TAG_W (TAG_W),
    .NODES  (NODES),  .SLOTS (SLOTS)
  ) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_br_vld  (wr_br_vld),
    .wr_br_kind (wr_br_kind),
    .wr_tgt     (wr_tgt),
    .rd_idx     (rd_idx),
    .rd_tag     (rd_tag),
    .rd_hit     (hit),
    .rd_br_vld  (rd_br_vld),
    .rd_br_kind (rd_br_kind),
    .rd_tgt     (rd_tgt)
  );

  btc_walk #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) walk_i (
    .hit      (hit),
    .pred     (pred_dir),
    .br_vld   (rd_br_vld),
    .br_kind  (rd_br_kind),
    .tgt      (rd_tgt),
    .lvl_vld  (lvl_vld),
    .lvl_addr (lvl_addr)
  );

  assign miss     = ~hit;
  assign seq_addr = fetch_addr + ADDR_W'(FETCH_BYTES);

  // R3: a miss produces no valid level.
  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (lvl_vld == '0));

  // R7: an unconditional primary branch always yields its taken slot at level 0.
  assert_uncond_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_br_vld[0] && (rd_br_kind[1:0] == btc_pkg::BR_UNCOND))
      |-> (lvl_addr[ADDR_W-1:0] == rd_tgt[2*ADDR_W-1:ADDR_W]));

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl_chk
    // R6: an invalid level drives a zero address.
    assert_invalid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_vld[k] |-> (lvl_addr[ADDR_W*k +: ADDR_W] == '0));
    if (k > 0) begin : g_chain
      // R6: a deeper level is never valid behind an invalid shallower one.
      assert_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_vld[k] |-> lvl_vld[k-1]);
    end
  end

endmodule

// File: tb/btc_top_tb.sv
module btc_top_tb_top;

  localparam int TCK = 10;
  localparam int AW  = 32;
  localparam int LV  = 2;
  localparam int NN  = 3;
  localparam int NS  = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [AW-1:0]  fetch_addr;
  logic [LV-1:0]  pred_dir;
  logic           hit, miss;
  logic [LV-1:0]  lvl_vld;
  logic [AW*LV-1:0] lvl_addr;
  logic [AW-1:0]  seq_addr;
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [NN-1:0]  wr_br_vld;
  logic [2*NN-1:0] wr_br_kind;
  logic [AW*NS-1:0] wr_tgt;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Bench-side model of installed entries (defaults: 16 entries, 24-bit tag).
  bit          m_pres [16];
  logic [23:0] m_tag  [16];
  logic [2:0]  m_vld  [16];
  logic [5:0]  m_kind [16];
  logic [31:0] m_tgt  [16][6];

  btc_top dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pred_dir(pred_dir),
    .hit(hit), .miss(miss), .lvl_vld(lvl_vld), .lvl_addr(lvl_addr),
    .seq_addr(seq_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_br_vld(wr_br_vld), .wr_br_kind(wr_br_kind), .wr_tgt(wr_tgt)
  );

  always #(TCK/2) clk = ~clk;

  function automatic logic [31:0] mk_addr(input logic [23:0] tg, input logic [3:0] ix,
                                          input logic [3:0] off);
    return {tg, ix, off};
  endfunction

  function automatic logic [AW*NS-1:0] mk_tgt(input int seed);
    logic [AW*NS-1:0] v;
    for (int s = 0; s < NS; s++) begin
      v[32*s +: 32] = {seed[19:0], s[3:0], 8'h40};
    end
    return v;
  endfunction

  // Expected {hit, miss, lvl_vld, lvl_addr, seq_addr} from the requirements.
  function automatic logic [99:0] expect_out(input logic [31:0] fa, input logic [1:0] pd);
    logic [3:0]  ix;
    logic [23:0] tg;
    logic        h, ch, d;
    logic [1:0]  v, ty;
    logic [63:0] a;
    int          node;
    ix = fa[7:4];
    tg = fa[31:8];
    h  = m_pres[ix] && (m_tag[ix] == tg);
    v  = '0;
    a  = '0;
    ch = h;
    node = 0;
    for (int k = 0; k < LV; k++) begin
      ch = ch && m_vld[ix][node];
      ty = m_kind[ix][2*node +: 2];
      d  = (ty == 2'b01) ? 1'b1 : (ty == 2'b11) ? 1'b0 : pd[k];
      if (ch) begin
        v[k] = 1'b1;
        a[32*k +: 32] = m_tgt[ix][2*node + int'(d)];
      end
      node = 2*node + 1 + int'(d);
    end
    return {h, !h, v, a, fa + 32'd16};
  endfunction

  task automatic compare(input string req);
    logic [99:0] exp_v, act_v;
    exp_v = expect_out(fetch_addr, pred_dir);
    act_v = {hit, miss, lvl_vld, lvl_addr, seq_addr};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s fa=%h pred=%b actual=%h expected=%h", req, fetch_addr, pred_dir,
               act_v, exp_v);
    end
  endtask

  task automatic look(input logic [31:0] fa, input logic [1:0] pd, input string req);
    @(negedge clk);
    fetch_addr = fa;
    pred_dir   = pd;
    #2;
    compare(req);
  endtask

  // Write an entry; a same-cycle lookup of that entry must return the old contents (R8).
  task automatic install(input logic [3:0] ix, input logic [23:0] tg, input logic [2:0] vl,
                         input logic [5:0] kd, input logic [AW*NS-1:0] tv);
    @(negedge clk);
    wr_addr    = mk_addr(tg, ix, 4'h0);
    wr_br_vld  = vl;
    wr_br_kind = kd;
    wr_tgt     = tv;
    wr_en      = 1'b1;
    fetch_addr = mk_addr(tg, ix, 4'h0);
    pred_dir   = 2'b11;
    #2;
    compare("R8 same-cycle old contents");
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_pres[ix] = 1'b1;
    m_tag[ix]  = tg;
    m_vld[ix]  = vl;
    m_kind[ix] = kd;
    for (int s = 0; s < NS; s++) m_tgt[ix][s] = tv[32*s +: 32];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) m_pres[i] = 1'b0;
    #3;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    failures++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [AW*NS-1:0] tv;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_br_vld = '0; wr_br_kind = '0;
    wr_tgt = '0; fetch_addr = '0; pred_dir = '0;
    for (int i = 0; i < 16; i++) begin
      m_pres[i] = 1'b0; m_tag[i] = '0; m_vld[i] = '0; m_kind[i] = '0;
      for (int s = 0; s < NS; s++) m_tgt[i][s] = '0;
    end
    #(TCK * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R2, R3: every index misses after reset; sequential address offered.
    for (int i = 0; i < 16; i++) look(mk_addr(24'h00ABC0 + 24'(i), 4'(i), 4'(i)), 2'(i), "R2 R3 reset miss");

    // Install every index with kinds derived from the index (R7, R9).
    for (int i = 0; i < 16; i++) begin
      logic [1:0] k0, k1;
      k0 = 2'(i);
      k1 = 2'(i >> 2);
      install(4'(i), 24'(i*37 + 5), 3'b111, {k0 ^ k1, k1, k0}, mk_tgt(i + 100));
    end

    // R4, R5, R7, R10: all indices, all prediction pairs, several offsets.
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 4; p++) begin
        look(mk_addr(24'(i*37 + 5), 4'(i), 4'h0), 2'(p), "R4 R5 R7 tree walk");
        look(mk_addr(24'(i*37 + 5), 4'(i), 4'h9), 2'(p), "R10 offset ignored");
        look(mk_addr(24'(i*37 + 5), 4'(i), 4'hF), 2'(p), "R10 offset ignored");
      end
      look(mk_addr(24'(i*37 + 6), 4'(i), 4'h0), 2'b01, "R1 tag mismatch miss");
    end

    // R6: every valid-bit pattern on one entry, all conditional branches.
    for (int v = 0; v < 8; v++) begin
      install(4'd6, 24'h06F00D, 3'(v), 6'b000000, mk_tgt(200 + v));
      for (int p = 0; p < 4; p++) look(mk_addr(24'h06F00D, 4'd6, 4'h4), 2'(p), "R6 path validity");
    end

    // R7: every primary/secondary kind pairing, all predictions.
    for (int t0 = 0; t0 < 4; t0++) begin
      for (int t1 = 0; t1 < 4; t1++) begin
        install(4'd9, 24'h000999, 3'b111, {2'(t1), 2'(t1), 2'(t0)}, mk_tgt(300 + 4*t0 + t1));
        for (int p = 0; p < 4; p++) look(mk_addr(24'h000999, 4'd9, 4'h0), 2'(p), "R7 kind encoding");
      end
    end

    // R9: fixed layout check with constant expectations.
    tv = '0;
    for (int s = 0; s < NS; s++) tv[32*s +: 32] = 32'h5000_0000 + 32'(s);
    install(4'd2, 24'h0000C2, 3'b111, 6'b000000, tv);
    @(negedge clk);
    fetch_addr = mk_addr(24'h0000C2, 4'd2, 4'h0);
    pred_dir   = 2'b01;
    #2;
    checks++;
    if ({lvl_vld, lvl_addr} !== {2'b11, 32'h5000_0004, 32'h5000_0001}) begin
      failures++;
      $display("FAIL R9 slot layout actual=%h expected=%h", {lvl_vld, lvl_addr},
               {2'b11, 32'h5000_0004, 32'h5000_0001});
    end

    // R8: replacing the tag makes the previous tag miss.
    install(4'd3, 24'h123456, 3'b111, 6'b000000, mk_tgt(400));
    look(mk_addr(24'(3*37 + 5), 4'd3, 4'h0), 2'b10, "R8 old tag misses");
    look(mk_addr(24'h123456, 4'd3, 4'h0), 2'b10, "R8 new tag hits");

    // R2: reset in mid-run clears every entry.
    do_reset();
    for (int i = 0; i < 16; i++) look(mk_addr(24'(i*37 + 5), 4'(i), 4'h0), 2'b11, "R2 reset clears");

    finish_run();
  end

endmodule